// File: doc/BRIEF.md
# Ripple-Chained 4-Bit ALU Slice

This block is a purely combinational arithmetic logic unit built from identical 4-bit slices. Each slice takes two 4-bit operands, a 3-bit operation code and a carry input. It returns a 4-bit result, a carry output and a twos-complement overflow flag. The operations are add, subtract in either direction, bitwise XOR, OR and AND, and two codes that force the result to all zeros or all ones.

The top level joins a parameterised number of slices (four by default, giving 16 bits) through their carries. The carry output of each slice feeds the carry input of the next more significant slice. The carry output and the overflow flag of the whole unit come from the most significant slice. The block holds no state and has no clock or reset. For subtraction the caller drives the carry input high, so a carry output of 1 after a subtraction means that no borrow occurred.

Top module: `alu_ripple_chain`

## Requirements
- R1: Operation code 3'b000 (sel[0] is the first select bit) forces result to all zeros, with carry_out and ovf_out both 0.
- R2: Operation code 3'b111 forces result to all ones, with carry_out and ovf_out both 0.
- R3: Operation code 3'b011 gives {carry_out, result} = a_in + b_in + carry_in as an unsigned sum one bit wider than the operands.
- R4: Operation code 3'b010 gives {carry_out, result} = a_in + ~b_in + carry_in. With carry_in = 1 the result is a_in minus b_in, and carry_out is 1 exactly when a_in >= b_in as unsigned values.
- R5: Operation code 3'b001 gives {carry_out, result} = b_in + ~a_in + carry_in. With carry_in = 1 the result is b_in minus a_in, and carry_out is 1 exactly when b_in >= a_in.
- R6: Operation codes 3'b100, 3'b101 and 3'b110 give a_in XOR b_in, a_in OR b_in and a_in AND b_in respectively. carry_in has no effect in these codes, and carry_out and ovf_out are 0.
- R7: In the three arithmetic codes, ovf_out is the XOR of the carry into and the carry out of the top result bit. It is therefore 1 exactly when the signed result of the add or subtract does not fit in the result width.
- R8: A carry produced in any bit travels through every slice boundary. For example, 0xFFFF + 0x0000 with carry_in = 1 gives a result of 0x0000 with carry_out = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | SLICE_W*NUM_SLICES (16) | First operand |
| b_in | input | SLICE_W*NUM_SLICES (16) | Second operand |
| sel | input | 3 | Operation code; sel[0] is the first select bit |
| carry_in | input | 1 | Carry into the least significant slice |
| result | output | SLICE_W*NUM_SLICES (16) | Operation result |
| carry_out | output | 1 | Carry out of the most significant slice |
| ovf_out | output | 1 | Twos-complement overflow of the most significant slice |

## Verification
The block has no state, so a wrong carry or wrong control decode shows at the ports in the same vector that triggers it. A broken carry link, however, shows only when the operands make a carry pass through that bit or slice boundary. For this reason the bench mixes all-ones, zero and sign-boundary operands with random ones. A wrong overflow term shows only at the signed limits. The bench therefore drives sums and differences across +32767/-32768 in all three arithmetic codes.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_CLEAR  = 3'b000,
    OP_BSUBA  = 3'b001,
    OP_ASUBB  = 3'b010,
    OP_ADD    = 3'b011,
    OP_XOR    = 3'b100,
    OP_OR     = 3'b101,
    OP_AND    = 3'b110,
    OP_PRESET = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    arith;
    logic    inv_a;
    logic    inv_b;
    alu_op_e op;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_mode_decode.sv
module alu_mode_decode
  import alu_pkg::*;
(
  input  logic [2:0] sel,
  output alu_ctrl_t  ctrl
);
  always_comb begin
    ctrl.op    = alu_op_e'(sel);
    ctrl.arith = (ctrl.op == OP_ADD) || (ctrl.op == OP_ASUBB) || (ctrl.op == OP_BSUBA);
    ctrl.inv_a = (ctrl.op == OP_BSUBA);
    ctrl.inv_b = (ctrl.op == OP_ASUBB);
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic [2:0]         sel,
  input  logic               cin,
  output logic [SLICE_W-1:0] f,
  output logic               cout,
  output logic               ovf
);
  alu_ctrl_t          ctrl;
  logic [SLICE_W-1:0] x_op;
  logic [SLICE_W-1:0] y_op;
  logic [SLICE_W-1:0] sum;
  logic [SLICE_W:0]   cy;

  alu_mode_decode u_dec (
    .sel  (sel),
    .ctrl (ctrl)
  );

  assign x_op  = a ^ {SLICE_W{ctrl.inv_a}};
  assign y_op  = b ^ {SLICE_W{ctrl.inv_b}};
  assign cy[0] = cin;

  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    assign sum[i]  = x_op[i] ^ y_op[i] ^ cy[i];
    assign cy[i+1] = (x_op[i] & y_op[i]) | (cy[i] & (x_op[i] ^ y_op[i]));
  end

  always_comb begin
    case (ctrl.op)
      OP_CLEAR:  f = '0;
      OP_PRESET: f = '1;
      OP_XOR:    f = a ^ b;
      OP_OR:     f = a | b;
      OP_AND:    f = a & b;
      default:   f = sum;
    endcase
  end

  assign cout = ctrl.arith & cy[SLICE_W];
  assign ovf  = ctrl.arith & (cy[SLICE_W] ^ cy[SLICE_W-1]);
endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain
  import alu_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 4
) (
  input  logic [SLICE_W*NUM_SLICES-1:0] a_in,
  input  logic [SLICE_W*NUM_SLICES-1:0] b_in,
  input  logic [2:0]                    sel,
  input  logic                          carry_in,
  output logic [SLICE_W*NUM_SLICES-1:0] result,
  output logic                          carry_out,
  output logic                          ovf_out
);
  localparam int TOT_W = SLICE_W * NUM_SLICES;

  logic [NUM_SLICES:0]   chain;
  logic [NUM_SLICES-1:0] slice_ovf;

  assign chain[0] = carry_in;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    alu_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a    (a_in[s*SLICE_W +: SLICE_W]),
      .b    (b_in[s*SLICE_W +: SLICE_W]),
      .sel  (sel),
      .cin  (chain[s]),
      .f    (result[s*SLICE_W +: SLICE_W]),
      .cout (chain[s+1]),
      .ovf  (slice_ovf[s])
    );
  end

  assign carry_out = chain[NUM_SLICES];
  assign ovf_out   = slice_ovf[NUM_SLICES-1];

  always_comb begin
    logic [TOT_W:0]   wide_ref;
    logic [TOT_W-1:0] xv;
    logic [TOT_W-1:0] yv;
    xv = (sel == 3'b001) ? ~a_in : a_in;
    yv = (sel == 3'b010) ? ~b_in : b_in;
    wide_ref = {1'b0, xv} + {1'b0, yv} + {{TOT_W{1'b0}}, carry_in};
    if (sel == 3'b000) begin
      // R1
      clear_out_chk: assert (result == '0 && !carry_out && !ovf_out)
        else $error("clear code output wrong");
    end
    if (sel == 3'b111) begin
      // R2
      preset_out_chk: assert (result == '1 && !carry_out && !ovf_out)
        else $error("preset code output wrong");
    end
    if (sel == 3'b011 || sel == 3'b010 || sel == 3'b001) begin
      // R3 R4 R5 R8
      arith_sum_chk: assert ({carry_out, result} == wide_ref)
        else $error("arithmetic sum or carry wrong");
      // R7
      signed_ovf_chk: assert (ovf_out == ((xv[TOT_W-1] == yv[TOT_W-1]) &&
                                          (result[TOT_W-1] != xv[TOT_W-1])))
        else $error("overflow flag wrong");
    end
    if (sel[2] && sel != 3'b111) begin
      // R6
      logic_flags_chk: assert (!carry_out && slice_ovf == '0)
        else $error("flags set in bitwise code");
    end
  end
endmodule

// File: tb/alu_ripple_chain_test.sv
module alu_ripple_chain_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic [W-1:0] a_in, b_in, result;
  logic [2:0]   sel;
  logic         carry_in, carry_out, ovf_out;
  int           n_checks = 0;
  int           n_fail   = 0;
  bit           done     = 0;

  always #10 clk = ~clk;

  alu_ripple_chain uut (
    .a_in      (a_in),
    .b_in      (b_in),
    .sel       (sel),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .ovf_out   (ovf_out)
  );

  function automatic logic [W+1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [2:0] s, input logic c);
    logic [W-1:0] x, y;
    logic [W:0]   t;
    logic         v;
    case (s)
      3'b000: return {2'b00, {W{1'b0}}};
      3'b111: return {2'b00, {W{1'b1}}};
      3'b100: return {2'b00, a ^ b};
      3'b101: return {2'b00, a | b};
      3'b110: return {2'b00, a & b};
      default: begin
        x = (s == 3'b001) ? ~a : a;
        y = (s == 3'b010) ? ~b : b;
        t = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        v = (x[W-1] == y[W-1]) && (t[W-1] != x[W-1]);
        return {v, t};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'b000: return "R1";
      3'b111: return "R2";
      3'b011: return "R3";
      3'b010: return "R4";
      3'b001: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [2:0] s, input logic c, input string tag);
    logic [W+1:0] exp, got;
    @(posedge clk);
    a_in = a; b_in = b; sel = s; carry_in = c;
    @(negedge clk);
    exp = model(a, b, s, c);
    got = {ovf_out, carry_out, result};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%b a=%h b=%h cin=%b: got ovf/cout/f=%b/%b/%h expected %b/%b/%h",
               tag, s, a, b, c, got[W+1], got[W], got[W-1:0], exp[W+1], exp[W], exp[W-1:0]);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corners [5];
    void'($urandom(32'd4711));
    corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h7FFF;
    corners[3] = 16'h8000; corners[4] = 16'h0001;
    a_in = '0; b_in = '0; sel = 3'b000; carry_in = 1'b0;
    // R1: initial all-zero input state
    apply(16'h0000, 16'h0000, 3'b000, 1'b0, "R1");
    // R8: carry travels through every slice boundary
    apply(16'hFFFF, 16'h0000, 3'b011, 1'b1, "R8");
    apply(16'h00FF, 16'h0001, 3'b011, 1'b0, "R8");
    apply(16'h0FFF, 16'h0000, 3'b010, 1'b1, "R8");
    // R7: signed limits in all three arithmetic codes
    apply(16'h7FFF, 16'h0001, 3'b011, 1'b0, "R7");
    apply(16'h8000, 16'h8000, 3'b011, 1'b0, "R7");
    apply(16'h8000, 16'h0001, 3'b010, 1'b1, "R7");
    apply(16'h0000, 16'h8000, 3'b010, 1'b1, "R7");
    apply(16'h0001, 16'h8000, 3'b001, 1'b1, "R7");
    apply(16'h7FFF, 16'h7FFF, 3'b001, 1'b1, "R7");
    // R6: carry_in has no effect in bitwise codes
    apply(16'hA5C3, 16'h0FF0, 3'b100, 1'b1, "R6");
    apply(16'hA5C3, 16'h0FF0, 3'b101, 1'b1, "R6");
    apply(16'hA5C3, 16'h0FF0, 3'b110, 1'b1, "R6");
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int c = 0; c < 2; c++)
            apply(corners[i], corners[j], 3'(s), 1'(c), tag_of(3'(s)));
      for (int k = 0; k < 300; k++)
        apply(16'($urandom), 16'($urandom), 3'(s), 1'($urandom), tag_of(3'(s)));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule